// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder, Constraint Length 3

This block is the forward-error-correction encoder at the front of a transmit path. Message bits arrive one at a time, each marked by a valid strobe. For every accepted bit the encoder emits one two-bit coded symbol. Both bits of the symbol are modulo-2 sums of the new bit and the two bits that came before it. The two stored bits form the encoder state, one of 00, 01, 10 or 11. Each new bit moves the encoder to one of two successor states. Encoding is fully serial: there is no frame buffer, and the memory shifts once per accepted bit.

A frame starts with a start-of-frame pulse, which zeroes the memory. If an input bit arrives in the same cycle as the pulse, that bit is encoded from the zeroed state. At the end of a frame a flush request appends two zero bits. Their two coded symbols leave on consecutive cycles, and a done pulse comes with the second one. The encoder is then back in state 00, so the trellis ends at a known point.

The control is a two-state machine. ST_RUN encodes offered bits. Its transitions are: stay on an input bit or an idle cycle; go to ST_TAIL on a flush request. ST_TAIL feeds zero bits. Its transitions are: stay while tail bits remain; return to ST_RUN after the last tail bit (tail complete); return to ST_RUN at once on a start-of-frame pulse (abort).

Top module: `conv_enc_r12`

## Requirements
- R1: Each accepted input bit produces exactly one two-bit symbol on `out_sym`, marked by `out_valid`, so the code rate is one half.
- R2: `out_sym[1]` is the XOR of the current bit and both stored bits (generator 111). `out_sym[0]` is the XOR of the current bit and the older stored bit only (generator 101). The newer stored bit is the input accepted immediately before.
- R3: Synchronous reset and `sof` both zero the stored bits. Reset also drives `out_valid`, `flush_done` and `out_sym` to 0. If `sof` and `in_valid` are high in the same cycle, `in_bit` is accepted and encoded with both stored bits taken as zero.
- R4: After `sof`, the bits 1,0,1,0,1,0,1,0 on consecutive cycles produce the symbols 11,10,00,10,00,10,00,10 in that order, written as `out_sym[1]`,`out_sym[0]`.
- R5: `out_valid` is high in the cycle after a bit is accepted, and only then or during a tail. `out_sym` keeps its last value while `out_valid` is low.
- R6: In ST_RUN, a cycle with `in_valid` low and no `sof` leaves the stored bits unchanged.
- R7: A `flush_req` accepted in ST_RUN produces two symbols that encode zero input bits. They appear on the second and third cycles after the request. `flush_done` is high together with the second symbol, and the stored bits are 00 afterwards.
- R8: While the tail runs, `in_valid`, `in_bit` and `flush_req` are ignored. In ST_RUN, `flush_req` takes priority over an input bit in the same cycle, and that bit is dropped.
- R9: `sof` during the tail aborts it. No `flush_done` is given, and the encoder restarts from state 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Start-of-frame: clear the encoder memory |
| in_valid | input | 1 | `in_bit` is offered this cycle |
| in_bit | input | 1 | Message bit |
| flush_req | input | 1 | Append the zero tail and return to state 00 |
| out_valid | output | 1 | `out_sym` holds a new coded symbol |
| out_sym | output | 2 | Coded symbol; bit 1 from generator 111, bit 0 from generator 101 |
| flush_done | output | 1 | High with the last tail symbol |

## Verification
The assertions check the following on every cycle: the valid timing after an accepted or idle cycle; that the memory holds across idle cycles; that `sof` clears the memory; that a request enters the tail and each tail cycle yields a symbol; and that `flush_done` coincides with a valid symbol and a zeroed memory. Only the bench scenarios can show that the symbol values are correct. These include the fixed known-answer sequence, random streams with gaps, tails with inputs offered during them, and aborted tails, all compared against an independent bit-level model.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TAIL = 1'b1
    } enc_state_e;
endpackage

// File: rtl/conv_enc_taps.sv
// Combinational generator network: one XOR-reduce per output bit.
module conv_enc_taps #(
    parameter int CL   = 3,
    parameter int NOUT = 2,
    parameter logic [NOUT-1:0][CL-1:0] GENS = {3'b111, 3'b101}
) (
    input  logic [CL-1:0]   win,   // win[CL-1] = current bit, win[0] = oldest
    output logic [NOUT-1:0] sym
);
    for (genvar g = 0; g < NOUT; g++) begin : g_out
        assign sym[g] = ^(win & GENS[g]);
    end
endmodule

// File: rtl/conv_enc_shreg.sv
// Encoder memory: the CL-1 most recent accepted bits, newest at the top.
module conv_enc_shreg #(
    parameter int CL = 3,
    localparam int MW = CL - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          shift,
    input  logic          din,
    output logic [MW-1:0] mem
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (shift) begin
            if (clr) mem <= {din, {(MW-1){1'b0}}};
            else     mem <= {din, mem[MW-1:1]};
        end else if (clr) begin
            mem <= '0;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(mem)); // R6
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (clr && !shift) |=> (mem == '0)); // R3
endmodule

// File: rtl/conv_enc_ctrl.sv
// Run/tail state machine.
module conv_enc_ctrl
    import conv_enc_pkg::*;
#(
    parameter int TAIL_LEN = 2,
    localparam int CNT_W = (TAIL_LEN > 1) ? $clog2(TAIL_LEN) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  logic       in_valid,
    input  logic       flush_req,
    output logic       shift_en,
    output logic       zero_feed,
    output logic       tail_last,
    output enc_state_e state
);
    enc_state_e       nxt;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_TAIL && nxt == ST_TAIL) ? cnt + 1'b1 : '0;
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        shift_en  = 1'b0;
        zero_feed = 1'b0;
        tail_last = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (sof) begin
                    shift_en = in_valid;
                end else if (flush_req) begin
                    nxt = ST_TAIL;
                end else begin
                    shift_en = in_valid;
                end
            end
            ST_TAIL: begin
                if (sof) begin
                    shift_en = in_valid;
                    nxt      = ST_RUN;
                end else begin
                    shift_en  = 1'b1;
                    zero_feed = 1'b1;
                    if (cnt == CNT_W'(TAIL_LEN - 1)) begin
                        tail_last = 1'b1;
                        nxt       = ST_RUN;
                    end
                end
            end
        endcase
    end

    AST_FLUSH_ENTERS_TAIL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && flush_req && !sof) |=> (state == ST_TAIL)); // R7
    AST_SOF_ABORTS: assert property (@(posedge clk) disable iff (rst)
        sof |=> (state == ST_RUN)); // R9
endmodule

// File: rtl/conv_enc_r12.sv
// Rate-1/2, constraint-length-3 convolutional encoder with zero-tail flush.
module conv_enc_r12
    import conv_enc_pkg::*;
#(
    parameter int CL   = 3,
    parameter logic [1:0][CL-1:0] GENS = {3'b111, 3'b101}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  logic       in_valid,
    input  logic       in_bit,
    input  logic       flush_req,
    output logic       out_valid,
    output logic [1:0] out_sym,
    output logic       flush_done
);
    localparam int MW = CL - 1;

    enc_state_e    state;
    logic          shift_en, zero_feed, tail_last;
    logic [MW-1:0] mem;
    logic          cur;
    logic [CL-1:0] win;
    logic [1:0]    sym;

    conv_enc_ctrl #(.TAIL_LEN(MW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .in_valid  (in_valid),
        .flush_req (flush_req),
        .shift_en  (shift_en),
        .zero_feed (zero_feed),
        .tail_last (tail_last),
        .state     (state)
    );

    assign cur = zero_feed ? 1'b0 : in_bit;
    assign win = {cur, (sof ? {MW{1'b0}} : mem)};

    conv_enc_shreg #(.CL(CL)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .clr   (sof),
        .shift (shift_en),
        .din   (cur),
        .mem   (mem)
    );

    conv_enc_taps #(.CL(CL), .NOUT(2), .GENS(GENS)) u_taps (
        .win (win),
        .sym (sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sym    <= '0;
            flush_done <= 1'b0;
        end else begin
            out_valid  <= shift_en;
            flush_done <= tail_last;
            if (shift_en) out_sym <= sym;
        end
    end

    AST_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sof || (state == ST_RUN && !flush_req))) |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !in_valid) |=> !out_valid); // R5
    AST_SYM_HELD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> (out_valid || $stable(out_sym))); // R5
    AST_TAIL_EMITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAIL && !sof) |=> out_valid); // R8
    AST_DONE_WITH_SYMBOL: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> (out_valid && mem == '0)); // R7
endmodule

// File: tb/test_conv_enc_r12.sv
module test_conv_enc_r12;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst, sof, in_valid, in_bit, flush_req;
    logic       out_valid, flush_done;
    logic [1:0] out_sym;

    int    checks   = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_req  = "R3";

    // reference model state
    int p1 = 0, p2 = 0, tail_left = 0;
    int ev = 0, esym = 0, edone = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_enc_r12 i_conv_enc_r12 (
        .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_bit(in_bit),
        .flush_req(flush_req), .out_valid(out_valid), .out_sym(out_sym),
        .flush_done(flush_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic encode(input int b);
        esym = (((b ^ p1 ^ p2) & 1) << 1) | ((b ^ p2) & 1);
        ev   = 1;
        p2   = p1;
        p1   = b;
    endtask

    task automatic model(input int r, input int s, input int v, input int b, input int f);
        edone = 0;
        if (r != 0) begin
            p1 = 0; p2 = 0; tail_left = 0; ev = 0; esym = 0;
        end else if (s != 0) begin
            p1 = 0; p2 = 0; tail_left = 0;
            if (v != 0) encode(b); else ev = 0;
        end else if (tail_left > 0) begin
            encode(0);
            tail_left--;
            if (tail_left == 0) edone = 1;
        end else if (f != 0) begin
            tail_left = 2;
            ev = 0;
        end else if (v != 0) begin
            encode(b);
        end else begin
            ev = 0;
        end
    endtask

    // drive one cycle after a falling edge, compare after the next falling edge
    task automatic cyc(input int r, input int s, input int v, input int b, input int f);
        rst = r[0]; sof = s[0]; in_valid = v[0]; in_bit = b[0]; flush_req = f[0];
        model(r, s, v, b, f);
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, "out_valid", int'(out_valid), ev);
        chk(cur_req, "flush_done", int'(flush_done), edone);
        chk(cur_req, "out_sym", int'(out_sym), esym);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] got;
        int nd;
        rst = 1; sof = 0; in_valid = 0; in_bit = 0; flush_req = 0;
        @(negedge clk);
        // R3: reset state
        cur_req = "R3";
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 1, 1, 0);
        chk("R3", "reset out_sym", int'(out_sym), 0);

        // R4: known-answer sequence, back to back after sof
        cur_req = "R4";
        got = '0;
        for (int i = 0; i < 8; i++) begin
            cyc(0, (i == 0) ? 1 : 0, 1, (i % 2 == 0) ? 1 : 0, 0);
            got = {got[13:0], out_sym};
        end
        chk("R4", "known-answer symbols", int'(got), int'(16'b11_10_00_10_00_10_00_10));

        // R6 / R5: gaps keep the memory and the symbol
        cur_req = "R6";
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 1, 0, 0);
        cur_req = "R5";
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0);

        // R7: flush, tail symbols on the 2nd and 3rd cycles
        cur_req = "R7";
        cyc(0, 0, 0, 0, 1);
        chk("R7", "no symbol in request cycle+1", int'(out_valid), 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R7", "flush_done with 2nd tail symbol", int'(flush_done), 1);
        cyc(0, 0, 1, 1, 0);
        chk("R7", "symbol from state 00 after flush", int'(out_sym), 3);

        // R8: inputs and a second request during the tail are ignored
        cur_req = "R8";
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 1, 1, 1);
        cyc(0, 0, 1, 1, 1);
        cyc(0, 0, 1, 1, 1);
        cyc(0, 0, 1, 1, 0);
        chk("R8", "memory zero after tail with offered bits", int'(out_sym), 3);
        // request and a bit in one cycle: bit dropped
        cyc(0, 0, 1, 1, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        // R9: sof aborts the tail
        cur_req = "R9";
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 0);
        chk("R9", "no done after abort", int'(flush_done), 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);

        // R3: sof mid-stream with and without a bit
        cur_req = "R3";
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 1, 1, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 1, 0);
        cyc(0, 1, 1, 0, 0);

        // R2 / R1: random streams with gaps, flushes and frame starts
        cur_req = "R2";
        nd = 0;
        for (int i = 0; i < 4000; i++) begin
            int rv;
            rv = int'($urandom_range(99));
            cyc(0, (rv < 2) ? 1 : 0, (rv % 5 != 0) ? 1 : 0,
                int'($urandom_range(1)), (rv > 96) ? 1 : 0);
            if (flush_done) nd++;
        end
        chk("R1", "random run saw completed flushes", (nd > 0) ? 1 : 0, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule